// File: doc/BRIEF.md
# Coherence Directory Slice Controller

This block is the home agent for one interleaved slice of physical memory in a multicore cache-coherent system. Every line address that maps to the slice has a directory entry: a line state (I, S, E or M) and a bit mask of the L1 cache agents that hold a copy. Caches never change a line state on their own. They send a transaction on the request channel, and the slice decides what happens. It sends invalidations, cache-to-cache transfer orders and state grants on the command channel. It counts acknowledgements on the response channel. It reads and writes backing memory through a simple request/acknowledge port.

The slice handles one transaction at a time. From acceptance until the final command to the requester is taken, the request channel is held not-ready. A request that arrives meanwhile waits on the channel and is never lost. This serializes all traffic to the slice's lines, so the caches never see a protocol race. The parameter `USE_E` selects MESI (a lone reader gets E) or MSI (a lone reader gets S). The lowest `SLICE_W` address bits choose the slice, so the directory index is the address shifted right by `SLICE_W`.

The sequencer uses nine named states. From ST_IDLE an accepted request branches to one of several states. Uncached requests go to ST_UC_MEM. Reads of a line owned elsewhere go to ST_XFER. Writes that find other holders go to ST_INV. The remaining cached requests go to ST_RD, or straight to ST_GRANT when the requester already holds the line. ST_INV issues one invalidate per holder and then moves to ST_ACKS, and so does ST_XFER. ST_ACKS waits until the received acknowledgements equal the expected count. It then moves to ST_WB if the old owner was dirty, otherwise to ST_RD or ST_GRANT. ST_WB moves to ST_RD or ST_GRANT. ST_RD moves to ST_GRANT. ST_GRANT writes the directory and returns to ST_IDLE. ST_UC_MEM moves to ST_UC_DONE, which returns to ST_IDLE.

Top module: `coh_dir_slice`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid and mem_req_valid are 0, and every directory line is I with no holders.
- R2: A cached read of a line with no holder performs one memory read (mem_req_write=0) of the request address. It then sends a fill command (cmd_kind=1) to the requester. The granted state is E (cmd_state=2) when USE_E=1 and S (cmd_state=1) when USE_E=0.
- R3: A cached read of a line held in S by other agents performs a memory read. It then fills the requester with S, and the requester is added to the holders.
- R4: A cached write first sends an invalidate (cmd_kind=2, cmd_state=0) to each other holder, in ascending agent order. It grants M (cmd_state=3) only after one acknowledgement per invalidate. The grant is a set-state command (cmd_kind=0) with no memory read if the requester already held the line. Otherwise it is a fill after a memory read.
- R5: A cached read of a line held in M or E by another agent sends a transfer command (cmd_kind=3, cmd_state=1) to the owner, naming the requester in cmd_requester. After the acknowledgement, a write-back (mem_req_write=1) follows if the owner was in M. A set-state S command to the requester completes the transaction, and both agents then hold S.
- R6: A cached write to a line held in M by another agent proceeds in this order: invalidate, acknowledgement, memory write-back, memory read, then a fill with M.
- R7: An uncached request performs one memory access with mem_req_write equal to req_write, then sends a done command (cmd_kind=4, cmd_state=0) to the requester. The directory entry is left unchanged.
- R8: req_ready is 0 from the cycle after acceptance until the final command of that transaction is taken. Only one transaction is ever open.
- R9: While cmd_valid is 1 and cmd_ready is 0, all command fields hold steady. While mem_req_valid is 1 and mem_ack is 0, the memory request holds steady.
- R10: No line ever has more than one agent in M or E, and an M or E holder never coexists with any other holder.
- R11: The directory index is req_addr >> SLICE_W. Addresses that differ only in the low SLICE_W bits share one entry, and every command and memory request carries the full request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request channel valid |
| req_ready | output | 1 | Request channel ready |
| req_write | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_uncached | input | 1 | 1 = bypass the directory |
| req_agent | input | AW | Requesting cache agent |
| req_addr | input | ADDR_W | Line address |
| cmd_valid | output | 1 | Command channel valid |
| cmd_ready | input | 1 | Command channel ready |
| cmd_kind | output | 3 | 0 set-state, 1 fill, 2 invalidate, 3 transfer, 4 done |
| cmd_dest | output | AW | Agent that receives the command |
| cmd_state | output | 2 | Line state to apply: 0 I, 1 S, 2 E, 3 M |
| cmd_requester | output | AW | Agent that opened the transaction (transfer target) |
| cmd_addr | output | ADDR_W | Line address |
| rsp_valid | input | 1 | One acknowledgement this cycle |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_ack | input | 1 | Memory access completes this cycle |

## Verification
A corrupted holder mask or line state in the directory does not show until the next request to that line. That request then gets the wrong command sequence: a fill where a transfer was due, a missing invalidate, or an E grant beside existing holders. The bench therefore keeps the cache-side state that the commands imply. It compares every transaction's command and memory sequence against a prediction made at acceptance. A miscounted acknowledgement shows within a transaction as a grant that comes before all invalidates have been acknowledged, or as a hang.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        CK_SET_STATE = 3'd0,
        CK_FILL      = 3'd1,
        CK_INV       = 3'd2,
        CK_XFER      = 3'd3,
        CK_DONE      = 3'd4
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INV,
        ST_XFER,
        ST_ACKS,
        ST_WB,
        ST_RD,
        ST_GRANT,
        ST_UC_MEM,
        ST_UC_DONE
    } seq_st_e;

endpackage

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
    parameter int N  = 4,
    parameter int AW = 2
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx
);
    // lowest set bit wins; zero vector yields index 0
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/coh_dir_array.sv
module coh_dir_array
    import coh_dir_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [1:0]          rd_state,
    output logic [N_AGENTS-1:0] rd_mask,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_state,
    input  logic [N_AGENTS-1:0] wr_mask
);
    localparam int LINES = 1 << IDX_W;

    logic [1:0]          st_q   [LINES];
    logic [N_AGENTS-1:0] mask_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= LN_I;
                mask_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                st_q[g]   <= wr_state;
                mask_q[g] <= wr_mask;
            end
        end
    end

    assign rd_state = st_q[rd_idx];
    assign rd_mask  = mask_q[rd_idx];

    AST_OWNER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_state == LN_M || wr_state == LN_E) |-> $onehot(wr_mask)); // R10
    AST_SHARED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_state == LN_S |-> wr_mask != '0); // R3
endmodule

// File: rtl/coh_dir_slice.sv
module coh_dir_slice
    import coh_dir_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ADDR_W   = 8,
    parameter int SLICE_W  = 2,
    parameter int USE_E    = 1,
    localparam int AW      = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_uncached,
    input  logic [AW-1:0]     req_agent,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_kind,
    output logic [AW-1:0]     cmd_dest,
    output logic [1:0]        cmd_state,
    output logic [AW-1:0]     cmd_requester,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              rsp_valid,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_ack
);
    localparam int IDX_W = ADDR_W - SLICE_W;
    localparam int CW    = $clog2(N_AGENTS + 1);

    seq_st_e state_q, state_d;

    logic [AW-1:0]       agent_q, owner_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                write_q, dirty_q, fill_q;
    logic [1:0]          grant_q;
    logic [N_AGENTS-1:0] inv_left_q, mask_new_q;
    logic [CW-1:0]       ack_need_q, ack_got_q;

    logic [1:0]          rd_state;
    logic [N_AGENTS-1:0] rd_mask, req_bit, others, inv_bit;
    logic [AW-1:0]       owner_pick, inv_pick;
    logic [CW-1:0]       others_cnt;
    logic                owned_other, last_inv, acks_done, accept, dir_we;

    coh_dir_array #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_addr[ADDR_W-1:SLICE_W]),
        .rd_state (rd_state),
        .rd_mask  (rd_mask),
        .wr_en    (dir_we),
        .wr_idx   (addr_q[ADDR_W-1:SLICE_W]),
        .wr_state (grant_q),
        .wr_mask  (mask_new_q)
    );

    coh_dir_pick #(.N(N_AGENTS), .AW(AW)) u_pick_owner (.vec(others),     .idx(owner_pick));
    coh_dir_pick #(.N(N_AGENTS), .AW(AW)) u_pick_inv   (.vec(inv_left_q), .idx(inv_pick));

    assign req_bit     = N_AGENTS'(1) << req_agent;
    assign others      = rd_mask & ~req_bit;
    assign owned_other = (rd_state == LN_M || rd_state == LN_E) && (others != '0);
    assign inv_bit     = N_AGENTS'(1) << inv_pick;
    assign last_inv    = (inv_left_q & ~inv_bit) == '0;
    assign acks_done   = ack_got_q == ack_need_q;
    assign accept      = req_valid && req_ready;

    always_comb begin
        others_cnt = '0;
        for (int i = 0; i < N_AGENTS; i++) others_cnt = others_cnt + CW'(others[i]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (req_uncached)        state_d = ST_UC_MEM;
                else if (!req_write)     state_d = owned_other ? ST_XFER : ST_RD;
                else if (others != '0)   state_d = ST_INV;
                else                     state_d = rd_mask[req_agent] ? ST_GRANT : ST_RD;
            end
            ST_INV:     if (cmd_ready && last_inv) state_d = ST_ACKS;
            ST_XFER:    if (cmd_ready) state_d = ST_ACKS;
            ST_ACKS:    if (acks_done) state_d = dirty_q ? ST_WB : (fill_q ? ST_RD : ST_GRANT);
            ST_WB:      if (mem_ack) state_d = fill_q ? ST_RD : ST_GRANT;
            ST_RD:      if (mem_ack) state_d = ST_GRANT;
            ST_GRANT:   if (cmd_ready) state_d = ST_IDLE;
            ST_UC_MEM:  if (mem_ack) state_d = ST_UC_DONE;
            ST_UC_DONE: if (cmd_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agent_q <= '0; owner_q <= '0; addr_q <= '0;
            write_q <= 1'b0; dirty_q <= 1'b0; fill_q <= 1'b0;
            grant_q <= LN_I; inv_left_q <= '0; mask_new_q <= '0;
            ack_need_q <= '0; ack_got_q <= '0;
        end else if (accept) begin
            agent_q    <= req_agent;
            addr_q     <= req_addr;
            write_q    <= req_write;
            owner_q    <= owner_pick;
            ack_got_q  <= '0;
            inv_left_q <= (req_write && !req_uncached) ? others : '0;
            if (req_write) begin
                ack_need_q <= others_cnt;
                dirty_q    <= (rd_state == LN_M) && (others != '0);
                fill_q     <= !rd_mask[req_agent];
                grant_q    <= LN_M;
                mask_new_q <= req_bit;
            end else if (owned_other) begin
                ack_need_q <= CW'(1);
                dirty_q    <= rd_state == LN_M;
                fill_q     <= 1'b0;
                grant_q    <= LN_S;
                mask_new_q <= rd_mask | req_bit;
            end else begin
                ack_need_q <= '0;
                dirty_q    <= 1'b0;
                fill_q     <= 1'b1;
                grant_q    <= (others != '0 || USE_E == 0) ? LN_S : LN_E;
                mask_new_q <= rd_mask | req_bit;
            end
        end else begin
            if (state_q == ST_INV && cmd_ready) inv_left_q <= inv_left_q & ~inv_bit;
            if (rsp_valid) ack_got_q <= ack_got_q + CW'(1);
        end
    end

    // outputs
    assign cmd_requester = agent_q;
    assign cmd_addr      = addr_q;
    assign mem_req_addr  = addr_q;

    always_comb begin
        req_ready     = 1'b0;
        cmd_valid     = 1'b0;
        cmd_kind      = CK_SET_STATE;
        cmd_dest      = agent_q;
        cmd_state     = LN_I;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        dir_we        = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_INV: begin
                cmd_valid = 1'b1; cmd_kind = CK_INV; cmd_dest = inv_pick;
            end
            ST_XFER: begin
                cmd_valid = 1'b1; cmd_kind = CK_XFER; cmd_dest = owner_q; cmd_state = LN_S;
            end
            ST_ACKS: ;
            ST_WB:      begin mem_req_valid = 1'b1; mem_req_write = 1'b1; end
            ST_RD:      mem_req_valid = 1'b1;
            ST_GRANT: begin
                cmd_valid = 1'b1;
                cmd_kind  = fill_q ? CK_FILL : CK_SET_STATE;
                cmd_state = grant_q;
                dir_we    = cmd_ready;
            end
            ST_UC_MEM:  begin mem_req_valid = 1'b1; mem_req_write = write_q; end
            ST_UC_DONE: begin cmd_valid = 1'b1; cmd_kind = CK_DONE; end
            default: ;
        endcase
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_kind, cmd_dest, cmd_state, cmd_requester, cmd_addr})); // R9
    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_ack |=> mem_req_valid && $stable({mem_req_write, mem_req_addr})); // R9
    AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R8
    AST_GRANT_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_state == LN_M |-> ack_got_q == ack_need_q); // R4
    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ack_got_q <= ack_need_q); // R4
    AST_UC_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == CK_DONE |-> !dir_we); // R7
endmodule

// File: tb/coh_dir_slice_bench.sv
module coh_dir_slice_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int AWD = 8;
    localparam int SW = 2;
    localparam int USE_E = 1;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_uncached = 0;
    logic [1:0] req_agent = 0;
    logic [AWD-1:0] req_addr = 0;
    logic req_ready, cmd_valid, mem_req_valid, mem_req_write;
    logic cmd_ready = 0, rsp_valid = 0, mem_ack = 0;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_dest, cmd_state, cmd_requester;
    logic [AWD-1:0] cmd_addr, mem_req_addr;

    coh_dir_slice #(.N_AGENTS(NA), .ADDR_W(AWD), .SLICE_W(SW), .USE_E(USE_E)) u_coh_dir_slice (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_uncached(req_uncached), .req_agent(req_agent),
        .req_addr(req_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_dest(cmd_dest), .cmd_state(cmd_state),
        .cmd_requester(cmd_requester), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_ack(mem_ack));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    int cst [NA][64];
    logic [31:0] exp_cmd [8], got_cmd [8], exp_mem [4], got_mem [4];
    int n_exp_cmd, n_got_cmd, n_exp_mem, n_got_mem;
    bit open = 0, r11_next = 0, hold_pend = 0;
    string tag;
    int t_idx, invs, acks_sent, pend, tmr, mcnt, r8_bad;
    logic [31:0] hold_pk;

    function automatic logic [31:0] pk(int k, int d, int s, int r, int a);
        return {15'd0, 3'(k), 2'(d), 2'(s), 2'(r), 8'(a)};
    endfunction

    task automatic check(input bit ok, input string t, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // prediction from the cache-side state, at acceptance
    task automatic plan(input int a, input int ad, input bit w, input bit uc);
        int idx, owner;
        bit any_other, had_m;
        idx = ad >> SW; t_idx = idx;
        n_exp_cmd = 0; n_exp_mem = 0; n_got_cmd = 0; n_got_mem = 0;
        invs = 0; acks_sent = 0;
        if (uc) begin
            exp_mem[n_exp_mem++] = {23'd0, w, 8'(ad)};
            exp_cmd[n_exp_cmd++] = pk(4, a, 0, a, ad);
            tag = "R7";
        end else if (!w) begin
            owner = -1; any_other = 0;
            for (int b = 0; b < NA; b++)
                if (b != a && cst[b][idx] != 0) begin
                    any_other = 1;
                    if (cst[b][idx] >= 2) owner = b;
                end
            if (owner >= 0) begin
                exp_cmd[n_exp_cmd++] = pk(3, owner, 1, a, ad);
                if (cst[owner][idx] == 3) exp_mem[n_exp_mem++] = {23'd0, 1'b1, 8'(ad)};
                exp_cmd[n_exp_cmd++] = pk(0, a, 1, a, ad);
                tag = "R5";
            end else begin
                exp_mem[n_exp_mem++] = {23'd0, 1'b0, 8'(ad)};
                exp_cmd[n_exp_cmd++] = pk(1, a, (any_other || USE_E == 0) ? 1 : 2, a, ad);
                tag = any_other ? "R3" : "R2";
            end
        end else begin
            had_m = 0;
            for (int b = 0; b < NA; b++)
                if (b != a && cst[b][idx] != 0) begin
                    exp_cmd[n_exp_cmd++] = pk(2, b, 0, a, ad);
                    if (cst[b][idx] == 3) had_m = 1;
                end
            if (had_m) exp_mem[n_exp_mem++] = {23'd0, 1'b1, 8'(ad)};
            if (cst[a][idx] != 0) exp_cmd[n_exp_cmd++] = pk(0, a, 3, a, ad);
            else begin
                exp_mem[n_exp_mem++] = {23'd0, 1'b0, 8'(ad)};
                exp_cmd[n_exp_cmd++] = pk(1, a, 3, a, ad);
            end
            tag = had_m ? "R6" : "R4";
        end
        if (r11_next) tag = "R11";
    endtask

    task automatic finish_txn();
        int nme, nnz;
        bit has_m;
        check(n_got_cmd == n_exp_cmd, tag, "command count", n_got_cmd, n_exp_cmd);
        for (int i = 0; i < n_exp_cmd && i < n_got_cmd; i++)
            check(got_cmd[i] == exp_cmd[i], tag, "command", got_cmd[i], exp_cmd[i]);
        check(n_got_mem == n_exp_mem, tag, "memory op count", n_got_mem, n_exp_mem);
        for (int i = 0; i < n_exp_mem && i < n_got_mem; i++)
            check(got_mem[i] == exp_mem[i], tag, "memory op", got_mem[i], exp_mem[i]);
        if (invs > 0) check(acks_sent == invs, "R4", "acks before grant", acks_sent, invs);
        nme = 0; nnz = 0; has_m = 0;
        for (int b = 0; b < NA; b++) begin
            if (cst[b][t_idx] >= 2) nme++;
            if (cst[b][t_idx] != 0) nnz++;
        end
        has_m = nme > 0;
        check(nme <= 1 && (!has_m || nnz == 1), "R10", "exclusive holders/total holders",
              {16'(nme), 16'(nnz)}, {16'd1, 16'd1});
        check(r8_bad == 0, "R8", "accepts or ready while open", r8_bad, 0);
    endtask

    // channel agents and monitor
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] cur;
            cur = pk(cmd_kind, cmd_dest, cmd_state, cmd_requester, cmd_addr);
            if (hold_pend) check(cmd_valid && cur == hold_pk, "R9", "command held", cur, hold_pk);
            cmd_ready = (cyc % 4) != 3;
            hold_pend = cmd_valid && !cmd_ready;
            hold_pk = cur;
            if (cmd_valid && cmd_ready) begin
                if (n_got_cmd < 8) got_cmd[n_got_cmd] = cur;
                n_got_cmd++;
                case (int'(cmd_kind))
                    2: begin cst[cmd_dest][cmd_addr >> SW] = 0; pend++; invs++; end
                    3: begin cst[cmd_dest][cmd_addr >> SW] = 1; pend++; invs++; end
                    0, 1: cst[cmd_dest][cmd_addr >> SW] = int'(cmd_state);
                    default: ;
                endcase
                if (cmd_kind == 0 || cmd_kind == 1 || cmd_kind == 4) begin
                    finish_txn();
                    open = 0;
                end
            end
            if (mem_ack) mem_ack = 0;
            else if (mem_req_valid) begin
                mcnt++;
                if (mcnt >= 2) begin
                    mem_ack = 1; mcnt = 0;
                    if (n_got_mem < 4) got_mem[n_got_mem] = {23'd0, mem_req_write, mem_req_addr};
                    n_got_mem++;
                end
            end
            rsp_valid = 0;
            if (pend > 0) begin
                if (tmr == 0) begin rsp_valid = 1; pend--; acks_sent++; tmr = 2; end
                else tmr--;
            end
            if (open && req_ready) r8_bad++;
            if (req_valid && req_ready) begin
                if (open) r8_bad++;
                plan(req_agent, req_addr, req_write, req_uncached);
                open = 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic issue(input int a, input int ad, input bit w, input bit uc, input bit r11);
        @(posedge clk); #1;
        req_valid = 1; req_agent = 2'(a); req_addr = 8'(ad);
        req_write = w; req_uncached = uc; r11_next = r11;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    initial begin
        logic [15:0] lf;
        int lines [3];
        lines = '{3, 10, 41};
        for (int b = 0; b < NA; b++) for (int i = 0; i < 64; i++) cst[b][i] = 0;
        pend = 0; tmr = 0; mcnt = 0; r8_bad = 0;
        n_got_cmd = 0; n_got_mem = 0; n_exp_cmd = 0; n_exp_mem = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
        check(cmd_valid == 0 && mem_req_valid == 0, "R1", "idle outputs", {cmd_valid, mem_req_valid}, 0);
        // R11: low address bits do not pick a different entry
        issue(0, (9 << SW) | 1, 0, 0, 0);
        issue(1, (9 << SW) | 2, 0, 0, 1);
        issue(2, (9 << SW) | 3, 1, 0, 0);
        issue(3, (9 << SW) | 0, 1, 0, 0);
        // uncached access beside an owned line, then owner still seen (R7)
        issue(1, (9 << SW) | 1, 1, 1, 0);
        issue(0, (9 << SW) | 1, 0, 0, 0);
        // sweep
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(int'(lf[1:0]), (lines[int'(lf[5:4]) % 3] << SW) | int'(lf[7:6]),
                  lf[9] & lf[8], lf[12:10] == 3'd5, 0);
        end
        while (open) @(negedge clk);
        repeat (5) @(negedge clk);
        summary();
    end
endmodule